// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Entry Character Queue

This block recovers asynchronous serial characters from a single input line. An outside baud generator supplies a one-cycle strobe at sixteen times the bit rate. A start edge is confirmed at the middle of the bit. After that, every data bit and the stop bit is settled by a two-of-three vote over the samples around mid-bit. Bits arrive least significant first and are collected in a shift register. A finished character, with its own framing flag and an optional ninth bit, is pushed into a small queue that the host drains one character per read strobe.

Reception runs only while both the port enable and the receive enable are high. The receive enable is a register: the host sets and clears it with pulses, and the block clears it on its own when a character arrives with the queue full. That event also raises a sticky overrun flag and drops the character. Taking the port enable low empties the queue and clears the overrun flag.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset, dataAvail, overrun, rxEnabled, irq and rdFrameErr are all 0.
- R2: Frames on the line are not received unless portEn and rxEnabled are both 1; rxEnSet raises rxEnabled and rxEnClr lowers it.
- R3: A low pulse that returns high before sample 8 of the start bit (sample 0 being the first tick that sees the line low) is discarded, and a later valid frame is still received correctly.
- R4: In 8-bit mode (nineBitMode=0) a frame is one low start bit, 8 data bits sent least significant bit first, and one stop bit. It is delivered on rdData with rdNinth=0.
- R5: Each data bit is decided by a majority of samples 7, 8 and 9 of its bit period, so a line glitch confined to one sample tick does not change the received value.
- R6: In 9-bit mode (nineBitMode=1) a ninth data bit follows the eighth on the line and appears on rdNinth alongside its character.
- R7: The queue holds two characters, and readPop removes the oldest one. dataAvail is 1 while the queue holds at least one character, and irq equals dataAvail AND irqEn.
- R8: A character that completes while both entries are unread is discarded. It sets overrun, which stays 1, and it clears rxEnabled, so later frames are ignored until rxEnSet.
- R9: A stop bit decided low is still stored with its character, and rdFrameErr is 1 while that character is at the head. A later character with a good stop bit reads rdFrameErr=0.
- R10: While portEn is 0 the queue is emptied and overrun is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| rxLine | input | 1 | Serial input line, idles high |
| portEn | input | 1 | Port enable; low flushes the queue and clears overrun |
| rxEnSet | input | 1 | Pulse that sets the receive enable |
| rxEnClr | input | 1 | Pulse that clears the receive enable |
| nineBitMode | input | 1 | 1 selects 9 data bits per character |
| irqEn | input | 1 | Interrupt enable |
| readPop | input | 1 | Host read strobe; pops the head character |
| rdData | output | 8 | Head character |
| rdNinth | output | 1 | Ninth bit of the head character |
| rdFrameErr | output | 1 | Framing error of the head character |
| dataAvail | output | 1 | Queue not empty |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky overrun flag |
| rxEnabled | output | 1 | Current receive enable |

## Verification
The host sees the block only through the head character and a few flags. A wrong internal state therefore shows up as a wrong value at the head entry, or as a flag in the wrong state, once the stop-bit vote of the affected frame has been taken. A counter off by one in the sample or bit count shifts or corrupts the delivered byte within that frame. A queue pointer or occupancy error shows up on the next pop, as a repeated or lost character or a dataAvail that drops too early. Errors in the enable logic show up as frames received while disabled, or as overrun failing to stop reception.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic takeFirst;   // latch early vote sample
    logic takeSecond;  // latch middle vote sample
    logic shiftBit;    // vote decided for a data bit
    logic frameDone;   // vote decided for the stop bit
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      active,
  input  logic      tick,
  input  logic      rxSync,
  input  logic      nineBit,
  output rxStrobe_t st
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DATA_W + 1);
  localparam int MID = OVS / 2;

  rxState_t      state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitIdx;
  logic [BW-1:0] lastIdx;
  logic          endOfBit;

  assign lastIdx  = nineBit ? BW'(DATA_W) : BW'(DATA_W - 1);
  assign endOfBit = (cnt == CW'(OVS - 1));

  always_comb begin
    st = '0;
    if (active && tick && (state == ST_DATA || state == ST_STOP)) begin
      st.takeFirst  = (cnt == CW'(MID - 1));
      st.takeSecond = (cnt == CW'(MID));
      st.shiftBit   = (state == ST_DATA) && (cnt == CW'(MID + 1));
      st.frameDone  = (state == ST_STOP) && (cnt == CW'(MID + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      cnt <= endOfBit ? '0 : cnt + 1'b1;
      case (state)
        ST_IDLE: begin
          cnt <= CW'(1);
          if (!rxSync) state <= ST_START;
        end
        ST_START: begin
          if (cnt == CW'(MID) && rxSync) state <= ST_IDLE;
          else if (endOfBit) begin
            state  <= ST_DATA;
            bitIdx <= '0;
          end
        end
        ST_DATA: begin
          if (endOfBit) begin
            if (bitIdx == lastIdx) state <= ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == CW'(MID + 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_dpath.sv
module serial_rx_dpath
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              rxLine,
  input  logic              rxEnSet,
  input  logic              rxEnClr,
  input  logic              nineBit,
  input  logic              readPop,
  input  rxStrobe_t         st,
  output logic              rxSync,
  output logic              rxEnabled,
  output logic [DATA_W-1:0] rdData,
  output logic              rdNinth,
  output logic              rdFrameErr,
  output logic              dataAvail,
  output logic              overrun
);
  localparam int SH_W = DATA_W + 1;
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW   = $clog2(DEPTH + 1);

  logic [1:0]        syncQ;
  logic              sampA, sampB, vote;
  logic [SH_W-1:0]   shiftReg;
  logic [DATA_W-1:0] memData  [DEPTH];
  logic              memNinth [DEPTH];
  logic              memFerr  [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr;
  logic [NW-1:0]     used;
  logic              notFull, doPop, doPush, doOvf;
  logic [DATA_W-1:0] newData;
  logic              newNinth;

  assign rxSync = syncQ[1];
  assign vote   = (sampA & sampB) | (sampA & rxSync) | (sampB & rxSync);

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end

  always_ff @(posedge clk) begin
    if (st.takeFirst)  sampA <= rxSync;
    if (st.takeSecond) sampB <= rxSync;
    if (st.shiftBit)   shiftReg <= {vote, shiftReg[SH_W-1:1]};
  end

  assign newData  = nineBit ? shiftReg[DATA_W-1:0] : shiftReg[SH_W-1:1];
  assign newNinth = nineBit & shiftReg[SH_W-1];

  assign notFull = (used != NW'(DEPTH));
  assign doPop   = readPop && (used != '0);
  assign doPush  = st.frameDone && (notFull || doPop);
  assign doOvf   = st.frameDone && !notFull && !doPop;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (doPush && wrPtr == PW'(g)) begin
        memData[g]  <= newData;
        memNinth[g] <= newNinth;
        memFerr[g]  <= ~vote;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !portEn) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      used    <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
      if (doOvf) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        rxEnabled <= 1'b0;
    else if (doOvf)   rxEnabled <= 1'b0;
    else if (rxEnClr) rxEnabled <= 1'b0;
    else if (rxEnSet) rxEnabled <= 1'b1;
  end

  assign dataAvail  = (used != '0);
  assign rdData     = memData[rdPtr];
  assign rdNinth    = memNinth[rdPtr] & dataAvail;
  assign rdFrameErr = memFerr[rdPtr] & dataAvail;
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              rxLine,
  input  logic              portEn,
  input  logic              rxEnSet,
  input  logic              rxEnClr,
  input  logic              nineBitMode,
  input  logic              irqEn,
  input  logic              readPop,
  output logic [DATA_W-1:0] rdData,
  output logic              rdNinth,
  output logic              rdFrameErr,
  output logic              dataAvail,
  output logic              irq,
  output logic              overrun,
  output logic              rxEnabled
);
  rxStrobe_t strobes;
  logic      rxSync;

  serial_rx_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .active(portEn && rxEnabled), .tick(tick16),
    .rxSync(rxSync), .nineBit(nineBitMode), .st(strobes)
  );

  serial_rx_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .portEn(portEn), .rxLine(rxLine),
    .rxEnSet(rxEnSet), .rxEnClr(rxEnClr), .nineBit(nineBitMode),
    .readPop(readPop), .st(strobes), .rxSync(rxSync), .rxEnabled(rxEnabled),
    .rdData(rdData), .rdNinth(rdNinth), .rdFrameErr(rdFrameErr),
    .dataAvail(dataAvail), .overrun(overrun)
  );

  assign irq = dataAvail & irqEn;
endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk (
  input logic clk,
  input logic rstN,
  input logic portEn,
  input logic readPop,
  input logic rxEnabled,
  input logic dataAvail,
  input logic overrun,
  input logic irq,
  input logic rdFrameErr
);
  a_r2_no_rx_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !(portEn && rxEnabled) && !readPop |=> !$rose(dataAvail));
  a_r8_overrun_disables: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> !rxEnabled);
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun && portEn |=> overrun);
  a_r10_port_off_clears: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> !overrun && !dataAvail);
  a_r7_irq_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> dataAvail);
  a_r9_ferr_needs_head: assert property (@(posedge clk) disable iff (!rstN)
    rdFrameErr |-> dataAvail);
endmodule

bind serial_rx_fifo serial_rx_fifo_chk u_chk (
  .clk(clk), .rstN(rstN), .portEn(portEn), .readPop(readPop),
  .rxEnabled(rxEnabled), .dataAvail(dataAvail), .overrun(overrun),
  .irq(irq), .rdFrameErr(rdFrameErr)
);

// File: tb/serial_rx_fifo_bench.sv
module serial_rx_fifo_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxLine = 1'b1;
  logic       portEn = 1'b0;
  logic       rxEnSet = 1'b0;
  logic       rxEnClr = 1'b0;
  logic       nineBitMode = 1'b0;
  logic       irqEn = 1'b0;
  logic       readPop = 1'b0;
  logic [7:0] rdData;
  logic       rdNinth, rdFrameErr, dataAvail, irq, overrun, rxEnabled;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_rx_fifo u_serial_rx_fifo (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine), .portEn(portEn),
    .rxEnSet(rxEnSet), .rxEnClr(rxEnClr), .nineBitMode(nineBitMode),
    .irqEn(irqEn), .readPop(readPop), .rdData(rdData), .rdNinth(rdNinth),
    .rdFrameErr(rdFrameErr), .dataAvail(dataAvail), .irq(irq),
    .overrun(overrun), .rxEnabled(rxEnabled)
  );

  typedef struct packed {
    logic       nine;
    logic       stopV;
    logic       glitch;
    logic [8:0] d;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 1'b0, 9'h0A5},
    '{1'b0, 1'b1, 1'b1, 9'h03C},
    '{1'b1, 1'b1, 1'b0, 9'h1C3},
    '{1'b1, 1'b1, 1'b1, 9'h055},
    '{1'b0, 1'b0, 1'b0, 9'h0F0},
    '{1'b0, 1'b1, 1'b0, 9'h0FF},
    '{1'b1, 1'b1, 1'b0, 9'h100}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic oneTick(input logic v);
    @(negedge clk) rxLine = v;
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk) tick16 = 1'b0;
  endtask

  task automatic idleTicks(input int n);
    for (int i = 0; i < n; i++) oneTick(1'b1);
  endtask

  task automatic sendFrame(input logic [8:0] d, input logic nine,
                           input logic stopV, input logic glitch);
    for (int s = 0; s < 16; s++) oneTick(1'b0);
    for (int b = 0; b < (nine ? 9 : 8); b++)
      for (int s = 0; s < 16; s++)
        oneTick((glitch && b == 2 && s == 8) ? ~d[b] : d[b]);
    for (int s = 0; s < 16; s++) oneTick(stopV);
    idleTicks(20);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dataAvail", dataAvail, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rxEnabled", rxEnabled, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rdFrameErr", rdFrameErr, 0);

    // R2: port enabled but receive disabled
    portEn = 1'b1;
    idleTicks(4);
    sendFrame(9'h05A, 1'b0, 1'b1, 1'b0);
    chk("R2 rx disabled ignores frame", dataAvail, 0);
    pulse(rxEnSet);
    chk("R2 rxEnSet", rxEnabled, 1);
    irqEn = 1'b1;
    idleTicks(4);

    // Table walk: R4 R5 R6 R9 R7
    for (int i = 0; i < NVEC; i++) begin
      nineBitMode = VECS[i].nine;
      sendFrame(VECS[i].d, VECS[i].nine, VECS[i].stopV, VECS[i].glitch);
      chk(VECS[i].glitch ? "R5 glitch data" : (VECS[i].nine ? "R6 data" : "R4 data"),
          rdData, VECS[i].d[7:0]);
      chk(VECS[i].nine ? "R6 ninth" : "R4 ninth zero", rdNinth,
          VECS[i].nine ? VECS[i].d[8] : 1'b0);
      chk("R9 frame error flag", rdFrameErr, !VECS[i].stopV);
      chk("R7 dataAvail", dataAvail, 1);
      chk("R7 irq", irq, 1);
      pulse(readPop);
      chk("R7 empty after pop", dataAvail, 0);
    end
    nineBitMode = 1'b0;

    // R7 irq gated by irqEn
    irqEn = 1'b0;
    sendFrame(9'h011, 1'b0, 1'b1, 1'b0);
    chk("R7 irq masked", irq, 0);
    chk("R7 data held", dataAvail, 1);
    pulse(readPop);
    irqEn = 1'b1;

    // R3 short start pulse
    for (int s = 0; s < 5; s++) oneTick(1'b0);
    idleTicks(24);
    chk("R3 short pulse dropped", dataAvail, 0);
    sendFrame(9'h0C9, 1'b0, 1'b1, 1'b0);
    chk("R3 frame after glitch", rdData, 8'hC9);
    pulse(readPop);

    // R9 per-entry framing error, R7 ordering
    sendFrame(9'h0E1, 1'b0, 1'b0, 1'b0);
    sendFrame(9'h01E, 1'b0, 1'b1, 1'b0);
    chk("R9 head ferr", rdFrameErr, 1);
    chk("R7 oldest first", rdData, 8'hE1);
    pulse(readPop);
    chk("R7 second entry", rdData, 8'h1E);
    chk("R9 second ferr clear", rdFrameErr, 0);
    chk("R7 still avail", dataAvail, 1);
    pulse(readPop);
    chk("R7 drained", dataAvail, 0);

    // R8 overrun
    sendFrame(9'h031, 1'b0, 1'b1, 1'b0);
    sendFrame(9'h032, 1'b0, 1'b1, 1'b0);
    chk("R8 no overrun at two", overrun, 0);
    sendFrame(9'h033, 1'b0, 1'b1, 1'b0);
    chk("R8 overrun set", overrun, 1);
    chk("R8 rx disabled", rxEnabled, 0);
    chk("R8 head kept", rdData, 8'h31);
    pulse(readPop);
    chk("R8 second kept", rdData, 8'h32);
    pulse(readPop);
    chk("R8 third discarded", dataAvail, 0);
    sendFrame(9'h044, 1'b0, 1'b1, 1'b0);
    chk("R8 ignored until re-enable", dataAvail, 0);
    pulse(rxEnSet);
    sendFrame(9'h045, 1'b0, 1'b1, 1'b0);
    chk("R8 receives after re-enable", rdData, 8'h45);
    chk("R8 overrun sticky", overrun, 1);

    // R10 port disable clears
    @(negedge clk) portEn = 1'b0;
    @(negedge clk);
    chk("R10 overrun cleared", overrun, 0);
    chk("R10 queue flushed", dataAvail, 0);
    sendFrame(9'h066, 1'b0, 1'b1, 1'b0);
    chk("R2 port off ignores frame", dataAvail, 0);
    portEn = 1'b1;
    pulse(rxEnClr);
    chk("R2 rxEnClr", rxEnabled, 0);

    summary();
  end
endmodule